// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Watchdog

This block guards the serial protocol engine of an SMBus target against a host that stalls with the clock line held low. It samples the raw SCL input through a synchronizer and counts consecutive system-clock cycles during which the synchronized clock stays low. When that run reaches a terminal count, the block issues a single-cycle pulse. The protocol engine uses this pulse to return its state machine to bus idle. The terminal count is derived from two parameters, the system clock frequency and a timeout in microseconds. The default timeout is 30 ms, which lies inside the required 25 ms to 35 ms window and leaves margin for oscillator drift on either side. Since a 10 kHz bus has low phases of about 50 us, legal traffic never gets close to the limit.

Two controls silence the watchdog. The first is a disable bit from the target's control register. Its reset value of 0 leaves the timeout active, and writing 1 turns it off. The second is a shutdown flag that marks the local oscillator as stopped. While either control is asserted, the low-time count is held at zero and no pulse can leave the block. The block only observes SCL and has no output toward the bus line.

Top module: `scl_low_watchdog`

## Requirements
- R1: During reset and after reset, with SCL high, `bus_idle_rst` is 0. The synchronizer flops reset to 1, so the bus reads as idle.
- R2: When `scl_in` is sampled low on TERM consecutive clock edges while the watchdog is active, `bus_idle_rst` goes to 1 in the cycle after the TERM-th edge of low seen at the synchronizer output. That output lags `scl_in` by 2 edges. TERM = CLK_HZ*TIMEOUT_US/1e6, which is 300 cycles for CLK_HZ=10000 and TIMEOUT_US=30000.
- R3: Each pulse lasts exactly one cycle. No second pulse is issued while SCL stays low, however long the low phase lasts, and the low-time count never goes above TERM.
- R4: Any synchronized high sample clears the count and rearms the pulse. A low phase of TERM-1 cycles produces no pulse, and neither do two shorter low phases separated by a one-cycle high glitch.
- R5: While `tmo_off` is 1, the count is held at zero and no pulse is issued in the following cycle. After `tmo_off` returns to 0 during a low phase, a full TERM further low cycles are needed before a pulse.
- R6: While `osc_stop` is 1, the count is held at zero and no pulse is issued in the following cycle. After `osc_stop` is released during a low phase, counting restarts from zero.
- R7: Once a pulse has fired in a low phase, toggling `tmo_off` or `osc_stop` during that same low phase does not produce another pulse. Only a synchronized high sample rearms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad, asynchronous |
| tmo_off | input | 1 | Control bit: 1 disables the timeout, 0 (reset value) enables it |
| osc_stop | input | 1 | Shutdown flag: 1 means the oscillator is stopped and the watchdog is silent |
| bus_idle_rst | output | 1 | One-cycle pulse telling the protocol engine to return to bus idle |

## Verification
The hardest situation to reach is the exact boundary of the count. This boundary sits behind the two-stage synchronizer, so it is shifted by two edges from anything the bench drives. The stimulus therefore applies low phases of exactly TERM-1 and exactly TERM raw cycles, plus a one-cycle high glitch inside a long low phase. A second hard case is re-entering the active state in the middle of a low phase, either after a pulse has already fired or before one has. The stimulus reaches it by toggling the disable bit and the shutdown flag while SCL is held low. A behavioural model compares the pulse output on every clock, and separate pulse-count checks cover each phase.

// File: rtl/smbto_pkg.sv
// Package: shared types and the cycle-count arithmetic for the SCL
// low-time watchdog. Assumes clock rates below 4.29 GHz.
package smbto_pkg;

    // State of the pulse generator: ready to fire, or already fired this low phase
    typedef enum logic {
        TRIP_ARMED = 1'b0,
        TRIP_FIRED = 1'b1
    } trip_state_e;

    // Convert a timeout in microseconds to a clock-cycle count, minimum 2
    function automatic int unsigned timeout_cycles(input int unsigned clk_hz,
                                                   input int unsigned tmo_us);
        longint unsigned prod;
        prod = (longint'(clk_hz) * longint'(tmo_us)) / 64'd1000000;
        if (prod < 64'd2) prod = 64'd2;
        return int'(prod);
    endfunction

endpackage

// File: rtl/scl_sync.sv
// Module: multi-flop synchronizer for the SCL pad level.
// Assumes the input is asynchronous to clk. The reset value is the bus-idle
// level (high), so reset never looks like a held-low clock.
module scl_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // First stage captures the asynchronous level
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= RESET_VAL;
        else        chain_q[0] <= d_in;
    end

    // Remaining stages settle metastability
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= RESET_VAL;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign q_out = chain_q[LAST];
endmodule

// File: rtl/low_timer.sv
// Module: saturating counter of consecutive active low-SCL cycles.
// Assumes clear is asserted on every cycle in which SCL is high or the
// watchdog is gated off. Flags the edge on which the count reaches TERM.
module low_timer #(
    parameter int unsigned TERM = 300,
    parameter int unsigned CW   = $clog2(TERM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] count,
    output logic          reach
);
    localparam logic [CW-1:0] LAST_LOW = CW'(TERM - 1);
    localparam logic [CW-1:0] TOP      = CW'(TERM);

    logic [CW-1:0] count_q;

    // The count reaches terminal on this edge when it advances from TERM-1
    assign reach = !clear && (count_q == LAST_LOW);

    // Count low cycles, hold at TERM, drop to zero on clear
    always_ff @(posedge clk) begin
        if (!rst_n)              count_q <= '0;
        else if (clear)          count_q <= '0;
        else if (count_q != TOP) count_q <= count_q + 1'b1;
    end

    assign count = count_q;
endmodule

// File: rtl/trip_gen.sv
// Module: turns the terminal-reach strobe into a single registered pulse
// per low phase. Assumes scl_high is the synchronized bus level; only a
// high sample rearms the generator.
module trip_gen
    import smbto_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reach,
    input  logic scl_high,
    output logic pulse
);
    trip_state_e state_q;
    logic        pulse_q;

    // Track whether this low phase has already produced its pulse
    always_ff @(posedge clk) begin
        if (!rst_n)                                  state_q <= TRIP_ARMED;
        else if (scl_high)                           state_q <= TRIP_ARMED;
        else if (reach && state_q == TRIP_ARMED)     state_q <= TRIP_FIRED;
    end

    // Register the pulse so the output is glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= reach && (state_q == TRIP_ARMED);
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/scl_low_watchdog.sv
// Module: SMBus clock-low timeout watchdog (top).
// Synchronizes SCL, counts how long it stays low while the watchdog is
// active (not disabled and oscillator running), and pulses bus_idle_rst for
// one cycle when the low time reaches the timeout. It never drives SCL.
// Assumes the disable bit comes from a register whose reset value is 0.
module scl_low_watchdog
    import smbto_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 1000000,
    parameter int unsigned TIMEOUT_US  = 30000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic tmo_off,
    input  logic osc_stop,
    output logic bus_idle_rst
);
    localparam int unsigned TERM_CYCLES = timeout_cycles(CLK_HZ, TIMEOUT_US);
    localparam int unsigned CNT_W       = $clog2(TERM_CYCLES + 1);

    logic             scl_s;
    logic             active;
    logic             clear;
    logic             reach;
    logic [CNT_W-1:0] low_cnt;

    scl_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (scl_in),
        .q_out (scl_s)
    );

    // Watchdog runs only when enabled and the oscillator is on
    assign active = !tmo_off && !osc_stop;
    assign clear  = !active || scl_s;

    low_timer #(
        .TERM (TERM_CYCLES),
        .CW   (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .count (low_cnt),
        .reach (reach)
    );

    trip_gen u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .reach    (reach),
        .scl_high (scl_s),
        .pulse    (bus_idle_rst)
    );
endmodule

// File: rtl/scl_low_watchdog_chk.sv
// Module: assertion checker bound to scl_low_watchdog.
// Relates the pulse to the pad level, the gating inputs and the counter.
module scl_low_watchdog_chk #(
    parameter int unsigned TERM = 300,
    parameter int unsigned CW   = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_in,
    input logic          tmo_off,
    input logic          osc_stop,
    input logic          bus_idle_rst,
    input logic          scl_s,
    input logic [CW-1:0] low_cnt
);
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle_rst |=> !bus_idle_rst);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= CW'(TERM));

    a_r2_pad_was_low: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle_rst |-> !$past(scl_in, 3));

    a_r2_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle_rst |-> ($past(low_cnt) == CW'(TERM - 1)));

    a_r4_clear_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        scl_s |=> (low_cnt == '0));

    a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_off |=> !bus_idle_rst);

    a_r6_shutdown_silent: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |=> (!bus_idle_rst && low_cnt == '0));
endmodule

bind scl_low_watchdog scl_low_watchdog_chk #(
    .TERM (TERM_CYCLES),
    .CW   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_in),
    .tmo_off      (tmo_off),
    .osc_stop     (osc_stop),
    .bus_idle_rst (bus_idle_rst),
    .scl_s        (scl_s),
    .low_cnt      (low_cnt)
);

// File: tb/scl_low_watchdog_bench.sv
// Bench: behavioural reference model compared on every clock, plus
// per-phase pulse-count checks. TERM = 10000 * 30000 / 1e6 = 300.
module scl_low_watchdog_bench;
    localparam int TERM = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic tmo_off = 1'b0;
    logic osc_stop = 1'b0;
    logic bus_idle_rst;

    int    vectors = 0;
    int    fails = 0;
    int    pulses = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state
    bit scl_hist[$];
    int run_len = 0;
    bit fired = 0;
    bit exp_pulse = 0;

    always #4 clk = ~clk;

    scl_low_watchdog #(
        .CLK_HZ      (10000),
        .TIMEOUT_US  (30000),
        .SYNC_STAGES (2)
    ) u_scl_low_watchdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_in),
        .tmo_off      (tmo_off),
        .osc_stop     (osc_stop),
        .bus_idle_rst (bus_idle_rst)
    );

    // Model: the design sees the pad level from two edges earlier
    always @(posedge clk) begin
        bit seen;
        bit on;
        if (!rst_n) begin
            scl_hist = '{1'b1, 1'b1};
            run_len = 0;
            fired = 0;
            exp_pulse = 0;
        end else begin
            seen = scl_hist[0];
            void'(scl_hist.pop_front());
            scl_hist.push_back(scl_in);
            on = !tmo_off && !osc_stop;
            if (!on || seen) begin
                exp_pulse = 0;
                run_len = 0;
            end else begin
                exp_pulse = (run_len == TERM - 1) && !fired;
                if (run_len < TERM) run_len++;
            end
            if (seen) fired = 0;
            else if (exp_pulse) fired = 1;
        end
    end

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        vectors++;
        if (bus_idle_rst) pulses++;
        if (bus_idle_rst !== exp_pulse) begin
            fails++;
            $display("FAIL %s cycle compare: actual=%b expected=%b at %0t",
                     cur_req, bus_idle_rst, exp_pulse, $time);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic low_for(input int n);
        scl_in = 1'b0;
        repeat (n) @(negedge clk);
        scl_in = 1'b1;
    endtask

    task automatic begin_phase(input string req);
        @(negedge clk);
        cur_req = req;
        pulses = 0;
    endtask

    task automatic check_count(input int expv);
        idle(8);
        vectors++;
        if (pulses != expv) begin
            fails++;
            $display("FAIL %s pulse count: actual=%0d expected=%0d", cur_req, pulses, expv);
        end
    endtask

    initial begin
        // R1: output quiet in and after reset
        repeat (5) @(negedge clk);
        vectors++;
        if (bus_idle_rst !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual=%b expected=0", bus_idle_rst);
        end
        rst_n = 1'b1;
        begin_phase("R1");
        check_count(0);

        // R2: exactly TERM low cycles trips once
        begin_phase("R2");
        low_for(TERM);
        check_count(1);

        // R2/R3: long low phase trips once only
        begin_phase("R3");
        low_for(3 * TERM);
        check_count(1);

        // R4: one cycle short of TERM does not trip
        begin_phase("R4");
        low_for(TERM - 1);
        check_count(0);

        // R4: high glitch splits the low phase and restarts counting
        begin_phase("R4");
        low_for(200);
        idle(1);
        low_for(200);
        check_count(0);

        // R5: disabled, long low phase is silent
        begin_phase("R5");
        tmo_off = 1'b1;
        low_for(2 * TERM);
        tmo_off = 1'b0;
        check_count(0);

        // R5: re-enable mid-low needs a full TERM more
        begin_phase("R5");
        tmo_off = 1'b1;
        scl_in = 1'b0;
        idle(100);
        tmo_off = 1'b0;
        idle(TERM - 1);
        vectors++;
        if (pulses != 0) begin
            fails++;
            $display("FAIL R5 early pulse: actual=%0d expected=0", pulses);
        end
        idle(20);
        scl_in = 1'b1;
        check_count(1);

        // R6: shutdown silences a long low phase
        begin_phase("R6");
        osc_stop = 1'b1;
        low_for(2 * TERM);
        osc_stop = 1'b0;
        check_count(0);

        // R6: shutdown in the middle restarts the count
        begin_phase("R6");
        scl_in = 1'b0;
        idle(250);
        osc_stop = 1'b1;
        idle(3);
        osc_stop = 1'b0;
        idle(250);
        scl_in = 1'b1;
        check_count(0);

        // R7: toggling gates after a trip does not re-fire
        begin_phase("R7");
        scl_in = 1'b0;
        idle(TERM + 10);
        tmo_off = 1'b1;
        idle(5);
        tmo_off = 1'b0;
        idle(TERM + 20);
        osc_stop = 1'b1;
        idle(5);
        osc_stop = 1'b0;
        idle(TERM + 20);
        scl_in = 1'b1;
        check_count(1);

        // R2: after rearm a fresh low phase trips again
        begin_phase("R2");
        low_for(TERM + 5);
        check_count(1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule